// File: doc/BRIEF.md
# Random excluded-tag address generator

This block picks a pseudo-random 4-bit memory tag and writes it into the tag field at the top of a 64-bit pointer. It carries its own state: a 16-bit LFSR seed and the tag it chose last. Each accepted request with tag access enabled steps the LFSR four times to build a 4-bit offset. Starting from the last tag, it then walks forward through the 16 tag values. The walk counts one unit of the offset only on a tag that the exclusion mask permits, and stops when the offset reaches zero. The chosen tag is stored as the new last tag. The tag written into the pointer is corrected by pointer bit 55. When tag access is disabled, the tag is zero and the state is left alone.

A request carries the pointer, a 16-bit exclusion operand and a tag-access enable. The operand is ORed with a configuration exclusion register. A small write port loads the seed or that register. The control is a four-state machine:

- S_IDLE: ready. A request moves it to S_DRAW when enabled, or straight to S_RESP when disabled.
- S_DRAW: one LFSR step per clock for four clocks, then S_WALK.
- S_WALK: one tag increment per clock. It moves to S_RESP when the offset is used up or the mask excludes every tag.
- S_RESP: a one-cycle response, then back to S_IDLE.

Top module: `tag_rand_gen`

## Requirements
- R1: Synchronous reset clears the seed, the last tag and the exclusion register to zero, leaves the block ready (req_ready=1) and holds rsp_valid low.
- R2: In S_IDLE, cfg_we with cfg_sel=0 loads the seed from cfg_wdata, and cfg_we with cfg_sel=1 loads the exclusion register from cfg_wdata[15:0]. A write made while a request is in flight is ignored.
- R3: Each enabled request takes exactly four LFSR steps. Each step computes fb = s[5]^s[3]^s[2]^s[0] and sets the new seed to {fb, s[15:1]}. The fb of step i (i=0..3) becomes bit i of the offset.
- R4: The effective mask is req_excl ORed with the exclusion register. Mask bit n set forbids tag value n.
- R5: Selection starts at the last tag and performs offset advances. Each advance adds 1 modulo 16 and keeps adding 1 while the resulting tag is excluded.
- R6: When the effective mask is all ones, no advance is made and the result is the last tag. The seed still takes its four steps.
- R7: With an offset of zero, the result is the last tag, even when that tag is excluded.
- R8: With req_tag_en low, the result tag is 0 and the seed and last tag are left unchanged.
- R9: After an enabled request, the last tag equals the result tag and the seed holds its value after the four steps.
- R10: rsp_ptr equals req_ptr with bits [59:56] replaced by (result tag − req_ptr[55]) mod 16. All other bits pass through unchanged.
- R11: A request is taken only while req_ready is high, and requests offered while busy are dropped. rsp_valid is a single-cycle pulse, followed by req_ready high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe (acted on only when idle) |
| cfg_sel | input | 1 | 0 selects the seed, 1 selects the exclusion register |
| cfg_wdata | input | 16 | Configuration write data |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | High when a request can be taken |
| req_ptr | input | 64 | Pointer to be tagged |
| req_excl | input | 16 | Per-request exclusion operand |
| req_tag_en | input | 1 | Tag access enable |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_ptr | output | 64 | Tagged pointer, valid with rsp_valid |

## Verification
The bench builds the block with its default parameters: a 64-bit pointer, 4-bit tags and a 16-bit seed. With 16 tag values and four draws, every single-tag exclusion, the fully excluded mask, the zero offset from a zero seed and both values of bit 55 can be swept in full. A mix of mask patterns generated in the bench then drives long walks past runs of excluded tags, while a model in the bench tracks the seed and last tag. Disabled requests, and requests and configuration writes made while busy, are placed between enabled ones. Any change they made to the state would therefore show up in the next result.

// File: rtl/tag_rand_pkg.sv
package tag_rand_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_DRAW = 2'd1,
        S_WALK = 2'd2,
        S_RESP = 2'd3
    } fsm_e;
endpackage

// File: rtl/tag_rand_lfsr.sv
module tag_rand_lfsr #(
    parameter int SEED_W = 16
) (
    input  logic [SEED_W-1:0] seed_i,
    output logic [SEED_W-1:0] seed_o,
    output logic              bit_o
);
    logic fb;
    assign fb     = seed_i[5] ^ seed_i[3] ^ seed_i[2] ^ seed_i[0];
    assign bit_o  = fb;
    assign seed_o = {fb, seed_i[SEED_W-1:1]};
endmodule

// File: rtl/tag_rand_insert.sv
module tag_rand_insert #(
    parameter int PTR_W   = 64,
    parameter int TAG_W   = 4,
    parameter int TAG_LSB = 56,
    parameter int ADJ_BIT = 55
) (
    input  logic [PTR_W-1:0] ptr_i,
    input  logic [TAG_W-1:0] tag_i,
    output logic [PTR_W-1:0] ptr_o
);
    generate
        if (ADJ_BIT >= 0) begin : g_adjust
            always_comb begin
                ptr_o = ptr_i;
                ptr_o[TAG_LSB +: TAG_W] = tag_i - {{(TAG_W-1){1'b0}}, ptr_i[ADJ_BIT]};
            end
        end else begin : g_plain
            always_comb begin
                ptr_o = ptr_i;
                ptr_o[TAG_LSB +: TAG_W] = tag_i;
            end
        end
    endgenerate
endmodule

// File: rtl/tag_rand_gen.sv
module tag_rand_gen
    import tag_rand_pkg::*;
#(
    parameter int PTR_W   = 64,
    parameter int TAG_W   = 4,
    parameter int SEED_W  = 16,
    parameter int TAG_LSB = 56,
    parameter int ADJ_BIT = 55
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic                  cfg_sel,
    input  logic [SEED_W-1:0]     cfg_wdata,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [PTR_W-1:0]      req_ptr,
    input  logic [(1<<TAG_W)-1:0] req_excl,
    input  logic                  req_tag_en,
    output logic                  rsp_valid,
    output logic [PTR_W-1:0]      rsp_ptr
);
    localparam int NTAGS   = 1 << TAG_W;
    localparam int DRAW_CW = (TAG_W > 1) ? $clog2(TAG_W) : 1;
    localparam logic [DRAW_CW-1:0] DRAW_LAST = DRAW_CW'(TAG_W - 1);

    fsm_e state_q, state_d;

    logic [SEED_W-1:0]  seed_q;
    logic [TAG_W-1:0]   prev_q;
    logic [NTAGS-1:0]   excl_q;
    logic [PTR_W-1:0]   ptr_q;
    logic [NTAGS-1:0]   mask_q;
    logic               en_q;
    logic [DRAW_CW-1:0] draw_q;
    logic [TAG_W-1:0]   cnt_q;
    logic [TAG_W-1:0]   offset_q;
    logic [TAG_W-1:0]   cur_q;

    logic [SEED_W-1:0]  seed_nxt;
    logic               rnd_bit;
    logic [TAG_W-1:0]   cand;
    logic               step_free;
    logic               mask_full;
    logic               walk_end;
    logic [TAG_W-1:0]   tag_out;

    tag_rand_lfsr #(.SEED_W(SEED_W)) u_lfsr (
        .seed_i (seed_q),
        .seed_o (seed_nxt),
        .bit_o  (rnd_bit)
    );

    assign cand      = cur_q + TAG_W'(1);
    assign step_free = ~mask_q[cand];
    assign mask_full = &mask_q;
    assign walk_end  = (cnt_q == '0) || mask_full;
    assign tag_out   = en_q ? cur_q : '0;

    tag_rand_insert #(
        .PTR_W(PTR_W), .TAG_W(TAG_W), .TAG_LSB(TAG_LSB), .ADJ_BIT(ADJ_BIT)
    ) u_insert (
        .ptr_i (ptr_q),
        .tag_i (tag_out),
        .ptr_o (rsp_ptr)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= S_IDLE;
        else     state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (req_valid) state_d = req_tag_en ? S_DRAW : S_RESP;
            S_DRAW: if (draw_q == DRAW_LAST) state_d = S_WALK;
            S_WALK: begin
                if (walk_end)                                  state_d = S_RESP;
                else if (step_free && cnt_q == TAG_W'(1))      state_d = S_RESP;
            end
            S_RESP: state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready = (state_q == S_IDLE);
        rsp_valid = (state_q == S_RESP);
    end

    // datapath
    always_ff @(posedge clk) begin
        if (rst) begin
            seed_q   <= '0;
            prev_q   <= '0;
            excl_q   <= '0;
            ptr_q    <= '0;
            mask_q   <= '0;
            en_q     <= 1'b0;
            draw_q   <= '0;
            cnt_q    <= '0;
            offset_q <= '0;
            cur_q    <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (cfg_we) begin
                        if (cfg_sel) excl_q <= cfg_wdata[NTAGS-1:0];
                        else         seed_q <= cfg_wdata;
                    end
                    if (req_valid) begin
                        ptr_q    <= req_ptr;
                        mask_q   <= req_excl | excl_q;
                        en_q     <= req_tag_en;
                        draw_q   <= '0;
                        cnt_q    <= '0;
                        offset_q <= '0;
                        cur_q    <= prev_q;
                    end
                end
                S_DRAW: begin
                    seed_q           <= seed_nxt;
                    cnt_q[draw_q]    <= rnd_bit;
                    offset_q[draw_q] <= rnd_bit;
                    draw_q           <= draw_q + DRAW_CW'(1);
                end
                S_WALK: begin
                    if (!walk_end) begin
                        cur_q <= cand;
                        if (step_free) cnt_q <= cnt_q - TAG_W'(1);
                    end
                end
                S_RESP: begin
                    if (en_q) prev_q <= cur_q;
                end
            endcase
        end
    end

    // assertions
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> (!rsp_valid && req_ready));                         // R11
    AST_DRAW_FOUR: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_DRAW && draw_q == DRAW_LAST) |=> (state_q == S_WALK)); // R3
    AST_OFF_HOLD_STATE: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_RESP && !en_q) |=> (seed_q == $past(seed_q) && prev_q == $past(prev_q))); // R8
    AST_LAND_FREE: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && en_q && !mask_full && offset_q != '0) |-> !mask_q[cur_q]); // R5
    AST_FULL_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && en_q && mask_full) |-> (cur_q == prev_q));            // R6
    AST_PASS_BITS: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_ptr[TAG_LSB-1:0] == ptr_q[TAG_LSB-1:0] &&
                       rsp_ptr[PTR_W-1:TAG_LSB+TAG_W] == ptr_q[PTR_W-1:TAG_LSB+TAG_W])); // R10
endmodule

// File: tb/tag_rand_gen_tb.sv
module tag_rand_gen_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_ptr = '0;
    logic [15:0] req_excl = '0;
    logic        req_tag_en = 1'b0;
    logic        rsp_valid;
    logic [63:0] rsp_ptr;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    logic [15:0] m_seed = '0;
    logic [3:0]  m_prev = '0;
    logic [15:0] m_excl = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tag_rand_gen u_dut (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_ptr(req_ptr),
        .req_excl(req_excl), .req_tag_en(req_tag_en),
        .rsp_valid(rsp_valid), .rsp_ptr(rsp_ptr)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            n_err = n_err + 1;
            $display("FAIL watchdog: run hung, got cycle %0d expected < 150000", cyc);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
            $finish;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_err = n_err + 1;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // reference model from the requirements
    task automatic model(input logic [63:0] ptr, input logic [15:0] op, input logic en,
                         output logic [63:0] exp);
        logic [15:0] mask;
        logic [3:0]  off;
        logic [3:0]  t;
        logic        fb;
        t = 4'd0;
        if (en) begin
            mask = op | m_excl;
            off = '0;
            for (int i = 0; i < 4; i++) begin
                fb = m_seed[5] ^ m_seed[3] ^ m_seed[2] ^ m_seed[0];
                m_seed = {fb, m_seed[15:1]};
                off[i] = fb;
            end
            t = m_prev;
            if (mask != 16'hffff) begin
                for (int k = 0; k < int'(off); k++) begin
                    t = t + 4'd1;
                    while (mask[t]) t = t + 4'd1;
                end
            end
            m_prev = t;
        end
        exp = ptr;
        exp[59:56] = t - {3'b000, ptr[55]};
    endtask

    task automatic cfg_write(input logic sel, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel) m_excl = d; else m_seed = d;
    endtask

    task automatic do_req(input logic [63:0] ptr, input logic [15:0] op, input logic en,
                          input string req);
        logic [63:0] exp;
        int k;
        model(ptr, op, en, exp);
        @(negedge clk);
        req_valid = 1'b1; req_ptr = ptr; req_excl = op; req_tag_en = en;
        @(negedge clk);
        req_valid = 1'b0;
        k = 0;
        while (!rsp_valid && k < 2000) begin
            @(negedge clk);
            k++;
        end
        check({req, " rsp_valid"}, 64'(rsp_valid), 64'd1);
        check(req, rsp_ptr, exp);
        @(negedge clk);
        check("R11 pulse/ready", {62'd0, rsp_valid, req_ready}, 64'd1);
    endtask

    logic [63:0] pat;
    logic [15:0] mg;
    logic [63:0] e_busy;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state at the ports
        check("R1 ready/valid", {62'd0, req_ready, rsp_valid}, 64'd2);
        // R1 + R7: zero seed gives offset 0; last tag 0 returned though excluded
        do_req(64'h0123_4567_89AB_CDEF & ~(64'h1 << 55), 16'h0001, 1'b1, "R7 zero offset");
        do_req(64'h0000_0000_0000_0000, 16'hFFFE, 1'b1, "R1 zero state");

        // R2 seed load, then R3/R5/R10 single-tag sweeps over both bit-55 values
        cfg_write(1'b0, 16'hACE1);
        pat = 64'hF0E1_D2C3_B4A5_9687;
        for (int b = 0; b < 2; b++) begin
            for (int n = 0; n < 16; n++) begin
                pat = {pat[62:0], pat[63] ^ pat[61]};
                pat[55] = b[0];
                do_req(pat, 16'(1 << n), 1'b1, "R5 R3 R10 single excl");
            end
        end

        // R6 all ones
        for (int i = 0; i < 4; i++)
            do_req(64'h8000_0000_0000_0000 | (64'(i) << 55), 16'hFFFF, 1'b1, "R6 all excluded");

        // R4 exclusion register ORed with operand
        cfg_write(1'b1, 16'h0F0F);
        for (int i = 0; i < 8; i++)
            do_req(64'h1234_5678_0000_0000 + 64'(i), 16'(16'h0030 << i), 1'b1, "R4 merged mask");
        cfg_write(1'b1, 16'h0000);

        // R8 disabled requests interleaved with enabled ones
        for (int i = 0; i < 6; i++) begin
            do_req(64'hFFFF_FFFF_FFFF_FFFF ^ (64'(i) << 55), 16'h0000, 1'b0, "R8 disabled");
            do_req(64'h0F0F_0000_1111_2222, 16'h1010, 1'b1, "R9 state after disabled");
        end

        // R11 + R2: request and config write during busy are dropped
        model(64'h0A0A_0A0A_0A0A_0A0A, 16'h0000, 1'b1, e_busy);
        @(negedge clk);
        req_valid = 1'b1; req_ptr = 64'h0A0A_0A0A_0A0A_0A0A; req_excl = '0; req_tag_en = 1'b1;
        @(negedge clk);
        req_valid = 1'b1; req_ptr = 64'hDEAD_BEEF_DEAD_BEEF; req_excl = 16'h7777;
        cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = 16'h5555;
        @(negedge clk);
        req_valid = 1'b0; cfg_we = 1'b0;
        begin
            int k = 0;
            while (!rsp_valid && k < 2000) begin @(negedge clk); k++; end
        end
        check("R11 busy first rsp", rsp_ptr, e_busy);
        begin
            int extra = 0;
            for (int i = 0; i < 30; i++) begin
                @(negedge clk);
                if (rsp_valid) extra++;
            end
            check("R11 no extra rsp", 64'(extra), 64'd0);
        end
        do_req(64'h3333_4444_5555_6666, 16'h0000, 1'b1, "R2 busy write ignored");

        // dense mask patterns: long walks
        mg = 16'h1D2B;
        for (int i = 0; i < 80; i++) begin
            mg = mg ^ (mg << 7); mg = mg ^ (mg >> 9); mg = mg ^ (mg << 8);
            if (i % 10 == 3) cfg_write(1'b1, {mg[7:0], mg[15:8]});
            do_req({mg, ~mg, mg ^ 16'h5A5A, 16'(i)}, mg, (i % 7) != 5, "R5 R9 mixed");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule